// File: doc/BRIEF.md
# Gated Card Clock Divider

This block derives the card clock of an MMC/SD host from the block clock `clk`. The block clock runs at twice the functional rate. A rate code picks the divide ratio. Codes 0 to 6 give a power-of-two division of the functional clock, so the card clock period is 2^(code+1) block-clock cycles, and code 0 gives the functional rate itself. Code 7 selects a separate fixed fast rate, whose half period is set by a parameter rather than by a shift.

Software presents a rate code and pulses `start` when it issues a command. The code is captured only at that moment. A running clock is never retimed, so software must pulse `stop` and wait for `clk_on` to fall before it reprograms anything. A stop is held back until it can close the gate without a shortened high phase. The block also gives a one-cycle enable tick aligned to each card-clock rising edge, for shifters that run on `clk`.

Top module: `ckdiv_gate`

## Requirements
- R1: After synchronous reset (active-low `rst_n`), `card_clk`, `card_ce` and `clk_on` are 0 and `rate_used` is 0.
- R2: With a captured code c in 0..6, `card_clk` has a period of 2^(c+1) `clk` cycles, and every high phase lasts 2^c cycles.
- R3: With captured code 7, `card_clk` has a period of 2*HS_HALF `clk` cycles, and every high phase lasts HS_HALF cycles.
- R4: When `start` is sampled while the clock is off, the code on `rate_code` is captured into `rate_used`. `card_clk` then rises exactly H cycles later, where H is the half period of that code. `clk_on` is 1 no later than two cycles after the start edge.
- R5: A `stop` sampled while the clock runs closes the gate only at a point where `card_clk` is, or is about to become, low. Every high phase, including the last one, therefore keeps its full length. `clk_on` then falls, and `card_clk` stays low with no `card_ce`.
- R6: A `start` sampled while the clock runs is ignored. `rate_used` and the period stay unchanged, whatever code is on `rate_code`.
- R7: A code captured at a later start after a stop takes effect: both `rate_used` and the period follow the new code.
- R8: `card_ce` is high for exactly the one `clk` cycle in which `card_clk` has just risen, and is low at all other times.
- R9: While the clock is off, a lone `stop`, or `start` and `stop` sampled together, leaves the clock off (stop has priority).
- R10: `clk_on` equals the gate state of the previous cycle, so it reports a change of the gate one cycle after it happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the functional rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_code | input | RATE_W | Rate code held by software (7 = fixed fast rate) |
| start | input | 1 | One-cycle strobe: enable the card clock with `rate_code` |
| stop | input | 1 | One-cycle strobe: halt the card clock at a safe point |
| card_clk | output | 1 | Divided, gated card clock |
| card_ce | output | 1 | One-cycle tick on each card-clock rising edge |
| clk_on | output | 1 | Status: card clock running |
| rate_used | output | RATE_W | Rate code latched at the last accepted start |

## Verification
Random runs cover every code, including the boundary codes 0 (toggle every cycle) and 6 (slowest), and the fast code 7. In each run the bench measures the first-rise latency, the full period and every high phase.

Stops arrive at random phases. A design that closed the gate during a high phase, or just before a rise, would leave a short high pulse. A design that waited for a toggle that never comes at code 0 would never stop.

Starts during a run carry a different code, and starts and stops also arrive while the clock is off. These catch a design that retimes a running clock, or one that lets start win over stop.

// File: rtl/ckdiv_pkg.sv
// Shared helpers for the gated card clock divider.
// Assumes the fast-rate code is the all-ones rate code.
package ckdiv_pkg;

    // Half period, in block-clock cycles, for a given rate code.
    function automatic int unsigned half_of(input int unsigned code,
                                            input int unsigned hs_code,
                                            input int unsigned hs_half);
        if (code == hs_code)
            return hs_half;
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/ckdiv_phase.sv
// Half-period counter and toggle flop that form the card clock.
// Assumes half >= 1 and that run only falls where the clock is low
// after the edge; while run is low the counter sits in its off state.
module ckdiv_phase #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             card_clk,
    output logic             card_ce,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    // Last cycle of the current half period.
    always_comb tick = (cnt_q == half - CNT_W'(1));

    // Count half periods, toggle the clock, mark each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q    <= '0;
            card_clk <= 1'b0;
            card_ce  <= 1'b0;
        end else if (tick) begin
            cnt_q    <= '0;
            card_clk <= ~card_clk;
            card_ce  <= ~card_clk;
        end else begin
            cnt_q    <= cnt_q + CNT_W'(1);
            card_ce  <= 1'b0;
        end
    end
endmodule

// File: rtl/ckdiv_gate_ctrl.sv
// Gate control: takes start/stop strobes, captures the rate code on an
// accepted start, and holds a stop until closing the gate is glitch-free.
// Assumes stop_ok is high in cycles where the clock will be low after
// the next edge.
module ckdiv_gate_ctrl #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              stop_ok,
    output logic              run,
    output logic [RATE_W-1:0] code,
    output logic              on
);
    logic stop_pend_q;

    // Gate state, pending stop and latched code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run         <= 1'b0;
            stop_pend_q <= 1'b0;
            code        <= '0;
        end else if (!run) begin
            stop_pend_q <= 1'b0;
            if (start && !stop) begin
                run  <= 1'b1;
                code <= rate_in;
            end
        end else if ((stop || stop_pend_q) && stop_ok) begin
            run         <= 1'b0;
            stop_pend_q <= 1'b0;
        end else if (stop) begin
            stop_pend_q <= 1'b1;
        end
    end

    // Status trails the gate by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) on <= 1'b0;
        else        on <= run;
    end
endmodule

// File: rtl/ckdiv_gate.sv
// Top of the gated card clock divider. Codes below the all-ones code
// give a half period of 2^code block cycles; the all-ones code gives
// HS_HALF. Assumes start and stop are single-cycle strobes in clk.
module ckdiv_gate #(
    parameter int RATE_W  = 3,
    parameter int HS_HALF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              start,
    input  logic              stop,
    output logic              card_clk,
    output logic              card_ce,
    output logic              clk_on,
    output logic [RATE_W-1:0] rate_used
);
    import ckdiv_pkg::*;

    localparam int HS_CODE  = (1 << RATE_W) - 1;
    localparam int MAX_HALF = 1 << (HS_CODE - 1);
    localparam int TOP_HALF = (MAX_HALF > HS_HALF) ? MAX_HALF : HS_HALF;
    localparam int CNT_W    = $clog2(TOP_HALF + 1);

    logic             run_w;
    logic             tick_w;
    logic             stop_ok_w;
    logic [CNT_W-1:0] half_w;

    // Half period selected by the latched code.
    always_comb half_w = CNT_W'(half_of(32'(rate_used), HS_CODE, HS_HALF));

    // Gate may close where the clock ends low: falling now or staying low.
    always_comb stop_ok_w = (tick_w == card_clk);

    ckdiv_gate_ctrl #(.RATE_W(RATE_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .stop    (stop),
        .rate_in (rate_code),
        .stop_ok (stop_ok_w),
        .run     (run_w),
        .code    (rate_used),
        .on      (clk_on)
    );

    ckdiv_phase #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .half     (half_w),
        .card_clk (card_clk),
        .card_ce  (card_ce),
        .tick     (tick_w)
    );
endmodule

// File: rtl/ckdiv_gate_chk.sv
// Property checker for ckdiv_gate, attached by bind below.
module ckdiv_gate_chk #(
    parameter int RATE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_w,
    input logic              card_clk,
    input logic              card_ce,
    input logic              clk_on,
    input logic [RATE_W-1:0] rate_used
);
    a_r8_ce_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        card_ce |-> (card_clk && !$past(card_clk)));

    a_r8_rise_has_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> card_ce);

    a_r10_status_on: assert property (@(posedge clk) disable iff (!rst_n)
        run_w |=> clk_on);

    a_r10_status_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |=> !clk_on);

    a_r6_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && $past(run_w)) |-> $stable(rate_used));

    a_r5_close_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_w) |-> !card_clk);

    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |-> (!card_clk && !card_ce));
endmodule

bind ckdiv_gate ckdiv_gate_chk #(.RATE_W(RATE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_w     (run_w),
    .card_clk  (card_clk),
    .card_ce   (card_ce),
    .clk_on    (clk_on),
    .rate_used (rate_used)
);

// File: tb/ckdiv_gate_test.sv
`timescale 1ns/1ps
module ckdiv_gate_test;
    localparam int RATE_W  = 3;
    localparam int HS_HALF = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [RATE_W-1:0] rate_code = '0;
    logic              start = 1'b0;
    logic              stop = 1'b0;
    logic              card_clk, card_ce, clk_on;
    logic [RATE_W-1:0] rate_used;

    int checks = 0;
    int fails = 0;
    int exp_half = 1;
    logic prev_clk = 1'b0;
    int hi_len = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ckdiv_gate #(.RATE_W(RATE_W), .HS_HALF(HS_HALF)) uut (
        .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .start(start),
        .stop(stop), .card_clk(card_clk), .card_ce(card_ce),
        .clk_on(clk_on), .rate_used(rate_used)
    );

    function automatic int half_of(input int code);
        return (code == 7) ? HS_HALF : (1 << code);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Continuous monitor: tick alignment (R8) and full high phases (R2/R3/R5).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(card_ce == (card_clk && !prev_clk), "R8 ce aligned to rise",
                  int'(card_ce), int'(card_clk && !prev_clk));
            if (card_clk) hi_len++;
            else if (prev_clk) begin
                check(hi_len == exp_half, "R2/R3/R5 high phase length", hi_len, exp_half);
                hi_len = 0;
            end
            prev_clk = card_clk;
        end
    end

    task automatic do_start(input int code);
        int k;
        rate_code = RATE_W'(code);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_half = half_of(code);
        k = 0;
        while (!card_clk && k < 200) begin
            @(negedge clk);
            k++;
            if (k == 2) check(clk_on == 1'b1, "R4 status within two cycles", int'(clk_on), 1);
        end
        if (k == 1) begin
            @(negedge clk);
            check(clk_on == 1'b1, "R4 status within two cycles", int'(clk_on), 1);
        end
        check(k == exp_half, "R4 first rise latency", k, exp_half);
        check(int'(rate_used) == code, "R4 code captured", int'(rate_used), code);
    endtask

    task automatic measure_period(input string req);
        int n;
        n = 0;
        while (card_clk && n < 300) begin @(negedge clk); n++; end
        n = 0;
        while (!card_clk && n < 300) begin @(negedge clk); n++; end
        n = 0;
        while (card_clk && n < 300) begin @(negedge clk); n++; end
        while (!card_clk && n < 300) begin @(negedge clk); n++; end
        check(n == 2 * exp_half, req, n, 2 * exp_half);
    endtask

    task automatic do_stop();
        int n;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        n = 0;
        while (clk_on && n < 200) begin @(negedge clk); n++; end
        check(!clk_on, "R5 status falls after stop", int'(clk_on), 0);
        for (int i = 0; i < 6; i++) begin
            check(!card_clk && !card_ce, "R5 clock quiet after stop",
                  int'(card_clk) + int'(card_ce), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        int unsigned seed_set;
        int code;
        seed_set = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!card_clk && !card_ce && !clk_on && rate_used == '0, "R1 reset state",
              int'(card_clk) + int'(card_ce) + int'(clk_on) + int'(rate_used), 0);

        // R9: lone stop and simultaneous start+stop while off
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        repeat (3) @(negedge clk);
        check(!clk_on && !card_clk, "R9 lone stop while off", int'(clk_on), 0);
        rate_code = 3'd2; start = 1'b1; stop = 1'b1;
        @(negedge clk); start = 1'b0; stop = 1'b0;
        repeat (4) @(negedge clk);
        check(!clk_on && !card_clk && rate_used == '0, "R9 stop wins over start",
              int'(clk_on), 0);

        // Directed boundary codes 0, 6 and the fast code 7
        do_start(0); measure_period("R2 period code 0"); do_stop();
        do_start(6); measure_period("R2 period code 6"); do_stop();
        do_start(7); measure_period("R3 period fast code"); do_stop();

        // R6: start during a run is ignored; R7: new code applies after restart
        do_start(3);
        @(negedge clk);
        rate_code = 3'd1; start = 1'b1; @(negedge clk); start = 1'b0;
        check(rate_used == 3'd3, "R6 code held during run", int'(rate_used), 3);
        measure_period("R6 period unchanged");
        do_stop();
        do_start(1);
        check(rate_used == 3'd1, "R7 new code after restart", int'(rate_used), 1);
        measure_period("R7 period follows new code");
        do_stop();

        // Random runs with random stop phase
        for (int it = 0; it < 24; it++) begin
            code = $urandom_range(0, 7);
            do_start(code);
            measure_period(code == 7 ? "R3 random period" : "R2 random period");
            if ($urandom_range(0, 1) == 1) begin
                rate_code = RATE_W'($urandom_range(0, 7));
                start = 1'b1; @(negedge clk); start = 1'b0;
                check(int'(rate_used) == code, "R6 random start ignored", int'(rate_used), code);
                measure_period("R6 random period held");
            end
            repeat ($urandom_range(0, 40)) @(negedge clk);
            do_stop();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule